// File: doc/BRIEF.md
# Daisy-Chain Device Addressing Logic

This block sits in each device of a daisy chain and decides whether that device responds. Each device holds two 16-bit values. The first is its own page address, which identifies it in the chain. The second is a device-select value, which names the device that the host wants to reach. The device is selected when the two values are equal. A device-select value of all ones is a broadcast code: every device is selected, but none of them may drive register readback, so that devices never fight over the bus.

The block also answers chain-wide next-free-address queries. When the enable-compare input is low, only one device answers. That is the device whose upstream full input is low, meaning every device before it is full, and whose own not-full flag is high. When the enable-compare input is high, only the device whose page address matches the select value answers.

Readback is registered. One cycle after a read request, the block raises a single drive enable and presents a 32-bit word. The word carries the register in its low half. The high half is zeros for the page address, and the upper status half for the other reads. A software reset leaves both stored values alone and only cancels a read that is in flight.

Top module: `chain_dev_select`

## Requirements
- R1: `selected` is high whenever the stored select value equals the stored page address. It follows a register write on the cycle after the write edge.
- R2: A stored select value of FFFFh makes `selected` high regardless of the page address. While that code is stored, page and select reads (`rd_kind` 0 and 1) never raise `rd_drive`.
- R3: A page-address write whose value is FFFFh is ignored, and the stored page address keeps its previous value. Any other value is stored.
- R4: A page read (`rd_kind`=0) returns zeros in bits 31..16 and the page address in bits 15..0. A select read (`rd_kind`=1) returns `status_hi` in bits 31..16 and the select value in bits 15..0. Both are driven only when the select value equals the page address.
- R5: `soft_rst` does not change the page address or the select value. It suppresses any read requested in the same cycle, and it clears `rd_drive` and `rd_data` on the following edge.
- R6: A next-free read (`rd_kind`=2) with `en_cmp` low drives if and only if `up_full_n` is low and `loc_full_n` is high. The word is {`status_hi`, `nf_val`}.
- R7: A next-free read with `en_cmp` high drives if and only if the select value equals the page address.
- R8: While `rst_n` is low, the page address and select value are 0000h, and `rd_drive` and `rd_data` are 0.
- R9: `rd_drive` is high only in the cycle after an accepted read request. With the default idle mode, `rd_data` is all zeros whenever `rd_drive` is low.
- R10: `rd_kind`=3 is reserved, and a read with it never raises `rd_drive`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| soft_rst | input | 1 | Software reset pulse |
| pa_wr | input | 1 | Page-address write strobe |
| ds_wr | input | 1 | Select-value write strobe |
| wr_val | input | 16 | Write value |
| rd_req | input | 1 | Read request |
| rd_kind | input | 2 | 0 page, 1 select, 2 next-free, 3 reserved |
| status_hi | input | 16 | Upper status half for readback |
| nf_val | input | 16 | Next-free address value |
| en_cmp | input | 1 | Enable-compare for next-free reads |
| up_full_n | input | 1 | Low when every upstream device is full |
| loc_full_n | input | 1 | High when this device has room |
| selected | output | 1 | Device accepts commands |
| rd_drive | output | 1 | Registered bus drive enable |
| rd_data | output | 32 | Registered readback word |

## Verification
The bench builds the block with a 16-bit address width and the zero-when-idle data variant. With that width the broadcast code is FFFFh, so the filtered page write and the broadcast read restriction can be reached directly. The zero-idle variant lets the bench check the data word on every cycle in which the block is not driving. The next-free tests step through the combinations of the upstream and local full flags under both settings of the enable-compare input.

// File: rtl/chain_sel_pkg.sv
package chain_sel_pkg;
   typedef enum logic [1:0] {
      RK_PAGE  = 2'd0,
      RK_DSEL  = 2'd1,
      RK_NFREE = 2'd2,
      RK_RSVD  = 2'd3
   } rd_kind_e;
endpackage

// File: rtl/chain_id_regs.sv
// Page-address and select-value storage; only hardware reset clears them.
module chain_id_regs #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pa_wr,
   input  logic              ds_wr,
   input  logic [ADDR_W-1:0] wr_val,
   output logic [ADDR_W-1:0] pa_q,
   output logic [ADDR_W-1:0] ds_q
);
   localparam logic [ADDR_W-1:0] BCAST = '1;

   logic pa_take;
   assign pa_take = pa_wr && (wr_val != BCAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pa_q <= '0;
         ds_q <= '0;
      end else begin
         if (pa_take) pa_q <= wr_val;
         if (ds_wr)   ds_q <= wr_val;
      end
   end
endmodule

// File: rtl/chain_match.sv
// Compares the stored select value against the page address.
module chain_match #(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] pa_q,
   input  logic [ADDR_W-1:0] ds_q,
   output logic              hit,
   output logic              bcast
);
   assign hit   = (ds_q == pa_q);
   assign bcast = &ds_q;
endmodule

// File: rtl/chain_read_port.sv
// Registered readback: picks the word and decides whether this device drives.
module chain_read_port
   import chain_sel_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter bit IDLE_ZERO = 1'b1,
   localparam int DATA_W   = 2 * ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              rd_req,
   input  rd_kind_e          kind,
   input  logic              hit,
   input  logic              en_cmp,
   input  logic              up_full_n,
   input  logic              loc_full_n,
   input  logic [ADDR_W-1:0] pa_q,
   input  logic [ADDR_W-1:0] ds_q,
   input  logic [ADDR_W-1:0] nf_val,
   input  logic [ADDR_W-1:0] status_hi,
   output logic              rd_drive,
   output logic [DATA_W-1:0] rd_data
);
   logic              go;
   logic [DATA_W-1:0] word;
   logic              accept;

   always_comb begin
      go   = 1'b0;
      word = '0;
      unique case (kind)
         RK_PAGE: begin
            go   = hit;
            word = {{ADDR_W{1'b0}}, pa_q};
         end
         RK_DSEL: begin
            go   = hit;
            word = {status_hi, ds_q};
         end
         RK_NFREE: begin
            go   = en_cmp ? hit : (!up_full_n && loc_full_n);
            word = {status_hi, nf_val};
         end
         default: begin
            go   = 1'b0;
            word = '0;
         end
      endcase
   end

   assign accept = rd_req && go && !soft_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_drive <= 1'b0;
      else        rd_drive <= accept;
   end

   generate
      if (IDLE_ZERO) begin : g_idle_zero
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      rd_data <= '0;
            else if (accept) rd_data <= word;
            else             rd_data <= '0;
         end
      end else begin : g_idle_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        rd_data <= '0;
            else if (soft_rst) rd_data <= '0;
            else if (accept)   rd_data <= word;
         end
      end
   endgenerate
endmodule

// File: rtl/chain_dev_select.sv
module chain_dev_select
   import chain_sel_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter bit IDLE_ZERO = 1'b1,
   localparam int DATA_W   = 2 * ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              pa_wr,
   input  logic              ds_wr,
   input  logic [ADDR_W-1:0] wr_val,
   input  logic              rd_req,
   input  logic [1:0]        rd_kind,
   input  logic [ADDR_W-1:0] status_hi,
   input  logic [ADDR_W-1:0] nf_val,
   input  logic              en_cmp,
   input  logic              up_full_n,
   input  logic              loc_full_n,
   output logic              selected,
   output logic              rd_drive,
   output logic [DATA_W-1:0] rd_data
);
   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("chain_dev_select: ADDR_W must be at least 2");
      end
   endgenerate

   logic [ADDR_W-1:0] pa_q;
   logic [ADDR_W-1:0] ds_q;
   logic              hit;
   logic              bcast;
   rd_kind_e          kind;

   assign kind     = rd_kind_e'(rd_kind);
   assign selected = hit || bcast;

   chain_id_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .pa_wr  (pa_wr),
      .ds_wr  (ds_wr),
      .wr_val (wr_val),
      .pa_q   (pa_q),
      .ds_q   (ds_q)
   );

   chain_match #(.ADDR_W(ADDR_W)) u_match (
      .pa_q  (pa_q),
      .ds_q  (ds_q),
      .hit   (hit),
      .bcast (bcast)
   );

   chain_read_port #(.ADDR_W(ADDR_W), .IDLE_ZERO(IDLE_ZERO)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (soft_rst),
      .rd_req     (rd_req),
      .kind       (kind),
      .hit        (hit),
      .en_cmp     (en_cmp),
      .up_full_n  (up_full_n),
      .loc_full_n (loc_full_n),
      .pa_q       (pa_q),
      .ds_q       (ds_q),
      .nf_val     (nf_val),
      .status_hi  (status_hi),
      .rd_drive   (rd_drive),
      .rd_data    (rd_data)
   );
endmodule

// File: rtl/chain_dev_select_chk.sv
module chain_dev_select_chk #(
   parameter int ADDR_W    = 16,
   parameter bit IDLE_ZERO = 1'b1,
   localparam int DATA_W   = 2 * ADDR_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              soft_rst,
   input logic              pa_wr,
   input logic              ds_wr,
   input logic [ADDR_W-1:0] wr_val,
   input logic              rd_req,
   input logic [1:0]        rd_kind,
   input logic              en_cmp,
   input logic              up_full_n,
   input logic              loc_full_n,
   input logic              selected,
   input logic              rd_drive,
   input logic [DATA_W-1:0] rd_data,
   input logic [ADDR_W-1:0] pa_q,
   input logic [ADDR_W-1:0] ds_q
);
   localparam logic [ADDR_W-1:0] BCAST = '1;

   assert_pa_never_bcast_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pa_q != BCAST);

   assert_pa_filtered_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pa_wr && wr_val == BCAST) |=> $stable(pa_q));

   assert_soft_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && !pa_wr && !ds_wr) |=> ($stable(pa_q) && $stable(ds_q)));

   assert_soft_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !rd_drive);

   assert_bcast_selects_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ds_q == BCAST) |-> selected);

   assert_bcast_no_reg_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_kind[1] == 1'b0 && ds_q == BCAST) |=> !rd_drive);

   assert_nf_chain_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_kind == 2'd2 && !en_cmp && !soft_rst)
      |=> (rd_drive == $past(!up_full_n && loc_full_n)));

   assert_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_kind == 2'd3) |=> !rd_drive);

   assert_drive_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_drive |-> $past(rd_req));

   generate
      if (IDLE_ZERO) begin : g_idle_chk
         assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_drive |-> (rd_data == '0));
      end
   endgenerate
endmodule

bind chain_dev_select chain_dev_select_chk #(.ADDR_W(ADDR_W), .IDLE_ZERO(IDLE_ZERO)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .soft_rst   (soft_rst),
   .pa_wr      (pa_wr),
   .ds_wr      (ds_wr),
   .wr_val     (wr_val),
   .rd_req     (rd_req),
   .rd_kind    (rd_kind),
   .en_cmp     (en_cmp),
   .up_full_n  (up_full_n),
   .loc_full_n (loc_full_n),
   .selected   (selected),
   .rd_drive   (rd_drive),
   .rd_data    (rd_data),
   .pa_q       (pa_q),
   .ds_q       (ds_q)
);

// File: tb/sim_chain_dev_select.sv
module sim_chain_dev_select;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 2 * AW;
   localparam int WATCHDOG_CYCLES = 5000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          soft_rst = 1'b0;
   logic          pa_wr = 1'b0;
   logic          ds_wr = 1'b0;
   logic [AW-1:0] wr_val = '0;
   logic          rd_req = 1'b0;
   logic [1:0]    rd_kind = 2'd0;
   logic [AW-1:0] status_hi = 16'hABCD;
   logic [AW-1:0] nf_val = 16'h0321;
   logic          en_cmp = 1'b1;
   logic          up_full_n = 1'b1;
   logic          loc_full_n = 1'b1;
   logic          selected;
   logic          rd_drive;
   logic [DW-1:0] rd_data;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   chain_dev_select #(.ADDR_W(AW), .IDLE_ZERO(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .pa_wr(pa_wr), .ds_wr(ds_wr),
      .wr_val(wr_val), .rd_req(rd_req), .rd_kind(rd_kind), .status_hi(status_hi),
      .nf_val(nf_val), .en_cmp(en_cmp), .up_full_n(up_full_n), .loc_full_n(loc_full_n),
      .selected(selected), .rd_drive(rd_drive), .rd_data(rd_data)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr_page(input logic [AW-1:0] v);
      @(negedge clk); pa_wr = 1'b1; wr_val = v;
      @(negedge clk); pa_wr = 1'b0;
   endtask

   task automatic wr_dsel(input logic [AW-1:0] v);
      @(negedge clk); ds_wr = 1'b1; wr_val = v;
      @(negedge clk); ds_wr = 1'b0;
   endtask

   // Issue one read and check the registered result on the next cycle.
   task automatic do_read(input string req, input logic [1:0] k,
                          input logic exp_drv, input logic [DW-1:0] exp_dat);
      @(negedge clk); rd_req = 1'b1; rd_kind = k;
      @(negedge clk); rd_req = 1'b0;
      check(req, {31'd0, rd_drive}, {31'd0, exp_drv});
      check(req, rd_data, exp_drv ? exp_dat : '0);
   endtask

   task automatic t_reset;
      check("R8 drive", {31'd0, rd_drive}, 32'd0);
      check("R8 data", rd_data, '0);
      check("R8/R1 selected 0==0", {31'd0, selected}, 32'd1);
      do_read("R8 page reads 0000", 2'd0, 1'b1, 32'h0000_0000);
   endtask

   task automatic t_match;
      wr_page(16'h1234);
      check("R1 mismatch", {31'd0, selected}, 32'd0);
      wr_dsel(16'h1234);
      check("R1 match", {31'd0, selected}, 32'd1);
   endtask

   task automatic t_readback;
      do_read("R4 page read", 2'd0, 1'b1, 32'h0000_1234);
      do_read("R4 select read", 2'd1, 1'b1, 32'hABCD_1234);
      @(negedge clk);
      check("R9 drive drops", {31'd0, rd_drive}, 32'd0);
      check("R9 idle data", rd_data, '0);
      wr_dsel(16'h0055);
      do_read("R4 no match no drive", 2'd1, 1'b0, '0);
      wr_dsel(16'h1234);
   endtask

   task automatic t_pa_filter;
      wr_page(16'hFFFF);
      do_read("R3 FFFF ignored", 2'd0, 1'b1, 32'h0000_1234);
      wr_page(16'h0042);
      wr_dsel(16'h0042);
      do_read("R3 other stored", 2'd0, 1'b1, 32'h0000_0042);
   endtask

   task automatic t_bcast;
      wr_dsel(16'hFFFF);
      check("R2 broadcast selected", {31'd0, selected}, 32'd1);
      do_read("R2 broadcast select read", 2'd1, 1'b0, '0);
      do_read("R2 broadcast page read", 2'd0, 1'b0, '0);
   endtask

   task automatic t_nf_chain;
      en_cmp = 1'b0;
      up_full_n = 1'b0; loc_full_n = 1'b1;
      do_read("R6 first free answers", 2'd2, 1'b1, 32'hABCD_0321);
      up_full_n = 1'b1; loc_full_n = 1'b1;
      do_read("R6 upstream has room", 2'd2, 1'b0, '0);
      up_full_n = 1'b0; loc_full_n = 1'b0;
      do_read("R6 self full", 2'd2, 1'b0, '0);
      up_full_n = 1'b1; loc_full_n = 1'b0;
      do_read("R6 both flags off", 2'd2, 1'b0, '0);
   endtask

   task automatic t_nf_match;
      en_cmp = 1'b1; up_full_n = 1'b0; loc_full_n = 1'b1;
      do_read("R7 broadcast no answer", 2'd2, 1'b0, '0);
      wr_dsel(16'h0042);
      do_read("R7 match answers", 2'd2, 1'b1, 32'hABCD_0321);
      wr_dsel(16'h0007);
      do_read("R7 mismatch silent", 2'd2, 1'b0, '0);
      wr_dsel(16'h0042);
   endtask

   task automatic t_soft;
      @(negedge clk); soft_rst = 1'b1;
      @(negedge clk); soft_rst = 1'b0;
      do_read("R5 page kept", 2'd0, 1'b1, 32'h0000_0042);
      do_read("R5 select kept", 2'd1, 1'b1, 32'hABCD_0042);
      @(negedge clk); soft_rst = 1'b1; rd_req = 1'b1; rd_kind = 2'd0;
      @(negedge clk); soft_rst = 1'b0; rd_req = 1'b0;
      check("R5 read cancelled", {31'd0, rd_drive}, 32'd0);
   endtask

   task automatic t_reserved;
      do_read("R10 reserved kind", 2'd3, 1'b0, '0);
   endtask

   task automatic t_hw_reset;
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R8 reset drive", {31'd0, rd_drive}, 32'd0);
      rst_n = 1'b1;
      do_read("R8 page cleared", 2'd0, 1'b1, 32'h0000_0000);
      do_read("R8 select cleared", 2'd1, 1'b1, 32'hABCD_0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_match();
      t_readback();
      t_pa_filter();
      t_bcast();
      t_nf_chain();
      t_nf_match();
      t_soft();
      t_reserved();
      t_hw_reset();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule